// File: doc/BRIEF.md
# Set/Clear/Toggle Register Bank for a Four-Channel Engine

This block holds the control and status registers of a coprocessor with up to four processing channels. It is reached over a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Every register can be written in four ways, selected by address bits 3:2 of the access:

- a plain overwrite;
- an OR of the written ones;
- a clear of the written ones;
- a toggle of the written ones.

Software can therefore change single bits without a read-modify-write. All four aliases read back the same value.

The bank has these registers:

- a global control word with per-channel interrupt enables;
- a global status word with sticky per-channel event flags and engine-driven fields;
- a channel control word;
- one group of four registers per channel (descriptor pointer, semaphore, channel status, options).

Completion and error pulses from the engines raise the flags. A completion pulse also counts down the channel semaphore. A per-channel interrupt line is formed from the flags and the enables. Setting the soft-reset bit returns the rest of the bank to its defaults.

Top module: `scb_regbank`

## Requirements
- R1: After reset the control word reads 0x7000_0000: bit 30 (clock gate) is 1, bits 29 and 28 (capability flags, both present by default) are 1, and all other bits are 0. Every other writable register reads 0.
- R2: A write at a register's base offset (address bits 3:2 = 0) replaces all its writable bits with the write data.
- R3: A write with address bits 3:2 = 1 ORs the data into the register, = 2 clears the bits written as one, and = 3 inverts the bits written as one.
- R4: A read at any of a register's four aliases returns the same value.
- R5: Writable bits are as follows:
  - control: 31, 30, 23, 22, 21 and bits 3:0;
  - status: flags at 3:0;
  - channel control: 16, 11:8 and 3:0.

  In the status word, bit 28 reflects key_ready, 27:24 reflect eng_active and 19:16 reflect eng_ready. Read-only and unused bits ignore every write form.
- R6: A done or error pulse on channel c sets status flag c. The flag stays set until software clears it. When a pulse and a software clear hit the same cycle, the pulse wins.
- R7: irq[c] is high exactly while status flag c and control bit c are both 1.
- R8: Channel c's registers sit at 0x100 + 0x40·c plus 0x00 (pointer, 32 bits), 0x10 (semaphore, bits 7:0), 0x20 (channel status, 32 bits) and 0x30 (options, 32 bits).
- R9: A done pulse on channel c decrements its semaphore when the semaphore is nonzero and leaves it at 0 otherwise. A bus write to that semaphore in the same cycle takes effect instead of the decrement.
- R10: An error pulse on channel c sets bit 0 of that channel's status register. The pulse wins over a same-cycle write.
- R11: While control bit 31 is 1, each clock edge returns every other register to its default. During that time, bus writes to any other bit and engine pulses have no effect. Bit 31 stays set until software clears it.
- R12: Accesses with address bits 1:0 nonzero, or to offsets that hold no register, read 0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| done_pulse | input | NCH | Per-channel completion pulse |
| err_pulse | input | NCH | Per-channel error pulse |
| eng_ready | input | NCH | Per-channel ready indication |
| eng_active | input | 4 | Number of the channel being served |
| key_ready | input | 1 | One-time key available |
| irq | output | NCH | Per-channel interrupt request |

## Verification
The assertions assume that a write strobe can change any register, so their claims about flag persistence, semaphore countdown and interrupt rise are conditioned on cycles with no bus write. They also assume that engine pulses last one cycle and are only meaningful outside soft reset. The bench drives pulses only between bus transactions, except in the deliberate collision cases of R6, R9 and R10. It keeps bit 31 out of the exhaustive alias sweep, so soft reset is entered only where R11 is tested.

// File: rtl/scb_regbank.sv
`timescale 1ns/1ps
module scb_regbank #(
  parameter int  NCH        = 4,
  parameter int  AW         = 12,
  parameter bit  HAS_CIPHER = 1'b1,
  parameter bit  HAS_HASH   = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_we,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] done_pulse,
  input  logic [NCH-1:0] err_pulse,
  input  logic [NCH-1:0] eng_ready,
  input  logic [3:0]     eng_active,
  input  logic           key_ready,
  output logic [NCH-1:0] irq
);
  localparam logic [31:0] CH_BITS  = 32'((64'd1 << NCH) - 1);
  localparam logic [31:0] CTRL_M   = 32'hC0E0_0000 | CH_BITS;
  localparam logic [31:0] CTRL_DEF = 32'h4000_0000;
  localparam logic [31:0] CCTL_M   = 32'h0001_0000 | (CH_BITS << 8) | CH_BITS;
  localparam logic [31:0] CAPS     = {2'b00, HAS_CIPHER, HAS_HASH, 28'h0};

  logic [31:0]          ctrl_q, cctl_q;
  logic [NCH-1:0]       flags_q;
  logic [31:0]          ptr_q [NCH];
  logic [31:0]          opt_q [NCH];
  logic [31:0]          cst_q [NCH];
  logic [NCH-1:0][7:0]  sema_q;

  wire       srst       = ctrl_q[31];
  wire [1:0] op         = bus_addr[3:2];
  wire       aligned    = bus_addr[1:0] == 2'b00;
  wire       hit_ctrl   = aligned && bus_addr[AW-1:4] == '0;
  wire       hit_stat   = aligned && bus_addr[AW-1:4] == (AW-4)'(1);
  wire       hit_cctl   = aligned && bus_addr[AW-1:4] == (AW-4)'(2);
  wire       chan_space = aligned && bus_addr[AW-1:8] == (AW-8)'(1);
  wire [1:0] chn        = bus_addr[7:6];
  wire [1:0] rsel       = bus_addr[5:4];

  logic [NCH-1:0] hit_ch;
  for (genvar c = 0; c < NCH; c++) begin : g_hit
    assign hit_ch[c] = chan_space && chn == 2'(c);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)      bus_rdata = ctrl_q | CAPS;
    else if (hit_stat) bus_rdata = {3'b000, key_ready, eng_active, 4'h0,
                                    4'(eng_ready), 12'h0, 4'(flags_q)};
    else if (hit_cctl) bus_rdata = cctl_q;
    else
      for (int c = 0; c < NCH; c++)
        if (hit_ch[c])
          case (rsel)
            2'd0: bus_rdata = ptr_q[c];
            2'd1: bus_rdata = {24'h0, sema_q[c]};
            2'd2: bus_rdata = cst_q[c];
            default: bus_rdata = opt_q[c];
          endcase
  end

  logic [31:0] wv;
  always_comb
    case (op)
      2'd0: wv = bus_wdata;
      2'd1: wv = bus_rdata | bus_wdata;
      2'd2: wv = bus_rdata & ~bus_wdata;
      default: wv = bus_rdata ^ bus_wdata;
    endcase

  logic [31:0]    ctrl_w;
  logic [NCH-1:0] flags_w;
  assign ctrl_w  = (bus_we && hit_ctrl) ? (wv & CTRL_M) : ctrl_q;
  assign flags_w = (bus_we && hit_stat) ? wv[NCH-1:0] : flags_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q  <= CTRL_DEF;
      flags_q <= '0;
      cctl_q  <= '0;
    end else if (srst) begin
      ctrl_q  <= {ctrl_w[31], CTRL_DEF[30:0]};
      flags_q <= '0;
      cctl_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_w;
      flags_q <= flags_w | done_pulse | err_pulse;
      if (bus_we && hit_cctl) cctl_q <= wv & CCTL_M;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || srst) begin
      for (int c = 0; c < NCH; c++) begin
        ptr_q[c]  <= '0;
        opt_q[c]  <= '0;
        cst_q[c]  <= '0;
        sema_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (bus_we && hit_ch[c] && rsel == 2'd0) ptr_q[c] <= wv;
        if (bus_we && hit_ch[c] && rsel == 2'd3) opt_q[c] <= wv;
        if (bus_we && hit_ch[c] && rsel == 2'd2)
          cst_q[c] <= wv | {31'h0, err_pulse[c]};
        else if (err_pulse[c])
          cst_q[c][0] <= 1'b1;
        if (bus_we && hit_ch[c] && rsel == 2'd1)
          sema_q[c] <= wv[7:0];
        else if (done_pulse[c] && sema_q[c] != 8'h0)
          sema_q[c] <= sema_q[c] - 8'd1;
      end
    end

  assign irq = flags_q & ctrl_q[NCH-1:0];
endmodule

module scb_regbank_chk #(
  parameter int NCH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_we,
  input logic                srst,
  input logic                gate,
  input logic [NCH-1:0]      ien,
  input logic [NCH-1:0]      flags_q,
  input logic [NCH-1:0][7:0] sema_q,
  input logic [NCH-1:0]      done_pulse,
  input logic [NCH-1:0]      err_pulse,
  input logic [NCH-1:0]      irq
);
  AST_SRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (flags_q == '0 && gate)); // R11

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && (done_pulse[c] || err_pulse[c])) |=> flags_q[c]); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !bus_we && flags_q[c]) |=> flags_q[c]); // R6
    AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !bus_we && ien[c] && done_pulse[c]) |=> irq[c]); // R7
    AST_SEMA_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !bus_we && done_pulse[c] && sema_q[c] != 8'h0)
        |=> sema_q[c] == $past(sema_q[c]) - 8'd1); // R9
  end
endmodule

bind scb_regbank scb_regbank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .srst(ctrl_q[31]),
  .gate(ctrl_q[30]), .ien(ctrl_q[NCH-1:0]), .flags_q(flags_q),
  .sema_q(sema_q), .done_pulse(done_pulse), .err_pulse(err_pulse),
  .irq(irq));

// File: tb/scb_regbank_test.sv
`timescale 1ns/1ps
module scb_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  done_pulse = '0, err_pulse = '0, eng_ready = '0, irq;
  logic [3:0]  eng_active = '0;
  logic        key_ready = 1'b0;
  int total = 0, bad = 0;

  scb_regbank uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
    .err_pulse(err_pulse), .eng_ready(eng_ready), .eng_active(eng_active),
    .key_ready(key_ready), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a; bus_we = 1'b0; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [3:0] d, input logic [3:0] e);
    @(negedge clk); done_pulse = d; err_pulse = e;
    @(negedge clk); done_pulse = '0; err_pulse = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic logic [31:0] model(input logic [31:0] cur, input int op,
                                        input logic [31:0] d, input logic [31:0] m);
    logic [31:0] n;
    n = (op == 0) ? d : (op == 1) ? (cur | d) : (op == 2) ? (cur & ~d) : (cur ^ d);
    return (cur & ~m) | (n & m);
  endfunction

  logic [11:0] ra [19];
  logic [31:0] rm [19];
  logic [31:0] ev [19];

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd(12'h000, 32'h7000_0000, "R1 ctrl");
    rd(12'h010, 32'h0, "R1 status");
    rd(12'h020, 32'h0, "R1 chanctl");
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        rd(12'(12'h100 + c*64 + r*16), 32'h0, "R1 channel");

    // R2 R3 R4 R8 exhaustive alias sweep over every writable register
    ra[0] = 12'h000; rm[0] = 32'h40E0_000F; ev[0] = 32'h4000_0000;
    ra[1] = 12'h010; rm[1] = 32'h0000_000F; ev[1] = 0;
    ra[2] = 12'h020; rm[2] = 32'h0001_0F0F; ev[2] = 0;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        ra[3+c*4+r] = 12'(12'h100 + c*64 + r*16);
        rm[3+c*4+r] = (r == 1) ? 32'hFF : 32'hFFFF_FFFF;
        ev[3+c*4+r] = 0;
      end
    for (int k = 0; k < 3; k++)
      for (int op = 0; op < 4; op++)
        for (int i = 0; i < 19; i++) begin
          logic [31:0] d;
          d = (32'hA5C3_0F96 ^ (32'(k*7 + op*3 + i) * 32'h1357_9BDF));
          if (i == 0) d[31] = 1'b0;
          wr(12'(ra[i] + op*4), d);
          ev[i] = model(ev[i], op, d, rm[i]);
          rd(ra[i], ev[i] | ((i == 0) ? 32'h3000_0000 : 32'h0),
             (op == 0) ? "R2 overwrite" : (i >= 3) ? "R3 R8 alias write" : "R3 alias write");
        end
    for (int i = 0; i < 19; i++)
      for (int al = 1; al < 4; al++)
        rd(12'(ra[i] + al*4), ev[i] | ((i == 0) ? 32'h3000_0000 : 32'h0), "R4 alias read");

    // R5 read-only fields
    do_reset();
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h000, 32'h0FFF_FFFF);
    rd(12'h000, 32'h30E0_000F, "R5 ctrl mask");
    rd(12'h010, 32'h0000_000F, "R5 status mask");
    wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, 32'h0001_0F0F, "R5 chanctl mask");
    @(negedge clk); key_ready = 1'b1; eng_active = 4'hA; eng_ready = 4'h5;
    wr(12'h01C, 32'hFFFF_FFF0);
    rd(12'h010, 32'h1A05_000F, "R5 status inputs");
    @(negedge clk); key_ready = 1'b0; eng_active = 4'h0; eng_ready = 4'h0;

    // R6 flags
    do_reset();
    pulse(4'b0100, 4'b0000);
    rd(12'h010, 32'h4, "R6 done sets flag");
    repeat (3) @(negedge clk);
    rd(12'h010, 32'h4, "R6 flag sticky");
    pulse(4'b0000, 4'b1000);
    rd(12'h010, 32'hC, "R6 error sets flag");
    wr(12'h018, 32'h4);
    rd(12'h010, 32'h8, "R6 clear alias ack");
    @(negedge clk); bus_addr = 12'h018; bus_we = 1'b1; bus_wdata = 32'h8; err_pulse = 4'b1000;
    @(negedge clk); bus_we = 1'b0; err_pulse = '0;
    rd(12'h010, 32'h8, "R6 pulse beats clear");

    // R7 irq sweep over flags and enables
    do_reset();
    for (int en = 0; en < 16; en++)
      for (int fl = 0; fl < 16; fl++) begin
        wr(12'h008, 32'hF);
        wr(12'h004, 32'(en));
        wr(12'h010, 32'(fl));
        #1 chk("R7 irq", 32'(irq), 32'(en & fl));
      end

    // R9 semaphore countdown
    do_reset();
    wr(12'h150, 32'h3);
    for (int n = 2; n >= 0; n--) begin
      pulse(4'b0010, 4'b0000);
      rd(12'h150, 32'(n), "R9 countdown");
    end
    pulse(4'b0010, 4'b0000);
    rd(12'h150, 32'h0, "R9 floor at zero");
    @(negedge clk); bus_addr = 12'h150; bus_we = 1'b1; bus_wdata = 32'h9; done_pulse = 4'b0010;
    @(negedge clk); bus_we = 1'b0; done_pulse = '0;
    rd(12'h150, 32'h9, "R9 write beats decrement");

    // R10 channel error bit
    pulse(4'b0000, 4'b0100);
    rd(12'h1A0, 32'h1, "R10 error bit");
    rd(12'h120, 32'h0, "R10 other channel untouched");
    @(negedge clk); bus_addr = 12'h1A0; bus_we = 1'b1; bus_wdata = 32'h50; err_pulse = 4'b0100;
    @(negedge clk); bus_we = 1'b0; err_pulse = '0;
    rd(12'h1A0, 32'h51, "R10 pulse beats write");

    // R12 unmapped and misaligned
    wr(12'h100, 32'hCAFE_0001);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h201, 32'hFFFF_FFFF);
    wr(12'h101, 32'h0);
    wr(12'h0F0, 32'hFFFF_FFFF);
    rd(12'h030, 32'h0, "R12 unmapped read");
    rd(12'h101, 32'h0, "R12 misaligned read");
    rd(12'h100, 32'hCAFE_0001, "R12 no side effect");
    rd(12'h000, 32'h7000_0000, "R12 ctrl untouched");

    // R11 soft reset
    wr(12'h008, 32'h4000_0000);
    wr(12'h004, 32'h00E0_0005);
    wr(12'h020, 32'h0001_0F0F);
    pulse(4'b0001, 4'b0000);
    rd(12'h000, 32'h30E0_0005, "R11 prep");
    wr(12'h004, 32'h8000_0000);
    wr(12'h100, 32'h1111_2222);
    pulse(4'b1111, 4'b1111);
    rd(12'h000, 32'hF000_0000, "R11 defaults while held");
    rd(12'h100, 32'h0, "R11 write ignored");
    rd(12'h010, 32'h0, "R11 pulses ignored");
    rd(12'h020, 32'h0, "R11 chanctl default");
    rd(12'h1A0, 32'h0, "R11 chan status default");
    #1 chk("R11 irq low", 32'(irq), 32'h0);
    wr(12'h008, 32'h8000_0000);
    rd(12'h000, 32'h7000_0000, "R11 release");
    wr(12'h100, 32'h1111_2222);
    rd(12'h100, 32'h1111_2222, "R11 writes resume");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule